// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between six asynchronous processor input pins and the core. It brings every pin into the clock domain through a two-stage synchronizer. It then compares the synchronized level with a stored copy of the level last seen on that pin. A pin whose level is unchanged causes no event. When a pin does change, the block decodes the event by that pin's own rule and then stores the new level as the pin's previous level.

Four pins feed a pending-interrupt vector: external interrupt, system management interrupt, machine check and soft reset. A summary request line is high while any pending bit is set. The machine-check bit is latched on a falling edge and is cleared by a one-cycle acknowledge.

The checkstop-in pin and the hard reset pin drive a small core-control state machine. It has three states:
- `CS_RUN`: the core runs.
- `CS_HALT`: the core is stopped.
- `CS_RSTP`: a one-cycle core-reset pulse is issued.

It has these transitions:
- `RUN->HALT` on a checkstop-in falling event.
- `HALT->RUN` on a checkstop-in rising event.
- `any->RSTP` on a hard-reset falling event. This transition has priority over the other two.
- `RSTP->RUN` or `RSTP->HALT`, according to the checkstop-in level just stored.

Top module: `irq_pin_conditioner`

## Requirements
- R1: After reset, `pending_o` is 0, `irq_req_o` is 0, `core_stop_o` is 0 and `core_rst_o` is 0. The stored previous level of a pin is 1 for `mck_n_i`, `chkstop_n_i` and `hreset_n_i`, and 0 for the other pins.
- R2: Each pin passes through two synchronizer flops and one event register. A change driven on a pin therefore reaches `pending_o` or the core-control outputs after the third rising clock edge, and not before.
- R3: `pending_o[0]` follows the external interrupt pin `ext_irq_i`, which is active high.
- R4: `pending_o[1]` follows the system management interrupt pin `smi_i`, which is active high.
- R5: `pending_o[2]` is set by a 1-to-0 change of `mck_n_i`. A 0-to-1 change of that pin has no effect on it.
- R6: `pending_o[2]` stays set until `mck_ack_i` is high for a cycle, which clears it. An acknowledge given while the bit is already clear has no effect.
- R7: `pending_o[3]` follows the soft reset pin `sreset_i`, which is active high.
- R8: `irq_req_o` is 1 exactly when at least one bit of `pending_o` is 1.
- R9: While `chkstop_n_i` is low, `core_stop_o` is 1. When the pin returns high, `core_stop_o` returns to 0.
- R10: Each 1-to-0 change of `hreset_n_i` produces exactly one `core_rst_o` pulse, one cycle wide. Holding the pin low, or raising it, produces no further pulse.
- R11: A pin whose synchronized level equals its stored previous level causes no change to any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| ext_irq_i | input | 1 | External interrupt pin, active high |
| smi_i | input | 1 | System management interrupt pin, active high |
| mck_n_i | input | 1 | Machine check pin, falling-edge sensitive |
| chkstop_n_i | input | 1 | Checkstop-in pin, active low |
| hreset_n_i | input | 1 | Hard reset pin, active low |
| sreset_i | input | 1 | Soft reset pin, active high |
| mck_ack_i | input | 1 | One-cycle clear of the machine-check pending bit |
| pending_o | output | 4 | Pending vector: [0] external, [1] system management, [2] machine check, [3] soft reset |
| irq_req_o | output | 1 | Summary interrupt request |
| core_stop_o | output | 1 | Core halt request |
| core_rst_o | output | 1 | One-cycle core reset pulse |

## Verification
The stimulus is a seeded random walk in which every step toggles an arbitrary subset of the six pins. Such steps separate the level pins, which track in both directions, from the machine-check pin, whose rising change must leave the pending bit untouched. They also exercise the stop and reset pins together, which exposes the priority of the reset pulse over halting.

Random acknowledges are issued both while the machine-check bit is set and while it is clear, to show that the bit holds until it is cleared. Directed cases cover the following:
- the exact three-edge latency;
- a hard-reset pin held low, which must give a single pulse;
- re-driving a pin with its current level, which must cause no event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NPIN   = 6;
    localparam int PEND_W = 4;

    // pin positions inside the synchronized vector
    localparam int PIN_EXT  = 0;
    localparam int PIN_SMI  = 1;
    localparam int PIN_MCK  = 2;
    localparam int PIN_STOP = 3;
    localparam int PIN_HRST = 4;
    localparam int PIN_SRST = 5;

    // idle level of each pin: 1 for the low-active or falling-edge pins
    localparam logic [NPIN-1:0] PIN_REST = 6'b01_1100;

    // positions in the pending vector
    localparam int PB_EXT  = 0;
    localparam int PB_SMI  = 1;
    localparam int PB_MCK  = 2;
    localparam int PB_SRST = 3;

    typedef enum logic [1:0] {
        CS_RUN  = 2'd0,
        CS_HALT = 2'd1,
        CS_RSTP = 2'd2
    } core_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int              W       = 6,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    INIT    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= INIT;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int           W    = 6,
    parameter logic [W-1:0] REST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] prev_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= REST;
        else        prev_q <= lvl_i;
    end

    assign prev_o = prev_q;
    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   lvl_i,
    input  logic [NPIN-1:0]   rise_i,
    input  logic [NPIN-1:0]   fall_i,
    input  logic              ack_i,
    output logic [PEND_W-1:0] pend_o
);
    logic [NPIN-1:0]   evt;
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] pend_d;

    assign evt = rise_i | fall_i;

    always_comb begin
        pend_d = pend_q;
        if (evt[PIN_EXT])  pend_d[PB_EXT]  = lvl_i[PIN_EXT];
        if (evt[PIN_SMI])  pend_d[PB_SMI]  = lvl_i[PIN_SMI];
        if (evt[PIN_SRST]) pend_d[PB_SRST] = lvl_i[PIN_SRST];
        if (fall_i[PIN_MCK])  pend_d[PB_MCK] = 1'b1;
        else if (ack_i)       pend_d[PB_MCK] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irqc_core_ctl.sv
module irqc_core_ctl
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_lvl_i,
    input  logic stop_rise_i,
    input  logic stop_fall_i,
    input  logic hrst_fall_i,
    output logic core_stop_o,
    output logic core_rst_o
);
    core_state_t state_q;
    core_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (hrst_fall_i) begin
            state_d = CS_RSTP;
        end else begin
            unique case (state_q)
                CS_RUN:  if (stop_fall_i) state_d = CS_HALT;
                CS_HALT: if (stop_rise_i) state_d = CS_RUN;
                CS_RSTP: state_d = stop_lvl_i ? CS_RUN : CS_HALT;
                default: state_d = CS_RUN;
            endcase
        end
    end

    always_comb begin
        core_stop_o = 1'b0;
        core_rst_o  = 1'b0;
        unique case (state_q)
            CS_RUN:  ;
            CS_HALT: core_stop_o = 1'b1;
            CS_RSTP: core_rst_o  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq_i,
    input  logic              smi_i,
    input  logic              mck_n_i,
    input  logic              chkstop_n_i,
    input  logic              hreset_n_i,
    input  logic              sreset_i,
    input  logic              mck_ack_i,
    output logic [PEND_W-1:0] pending_o,
    output logic              irq_req_o,
    output logic              core_stop_o,
    output logic              core_rst_o
);
    logic [NPIN-1:0] raw_pins;
    logic [NPIN-1:0] sync_lvl;
    logic [NPIN-1:0] prev_lvl;
    logic [NPIN-1:0] rise;
    logic [NPIN-1:0] fall;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_EXT]  = ext_irq_i;
        raw_pins[PIN_SMI]  = smi_i;
        raw_pins[PIN_MCK]  = mck_n_i;
        raw_pins[PIN_STOP] = chkstop_n_i;
        raw_pins[PIN_HRST] = hreset_n_i;
        raw_pins[PIN_SRST] = sreset_i;
    end

    irqc_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .INIT(PIN_REST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (sync_lvl)
    );

    irqc_edge #(.W(NPIN), .REST(PIN_REST)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lvl),
        .prev_o (prev_lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    irqc_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lvl),
        .rise_i (rise),
        .fall_i (fall),
        .ack_i  (mck_ack_i),
        .pend_o (pending_o)
    );

    irqc_core_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_lvl_i  (sync_lvl[PIN_STOP]),
        .stop_rise_i (rise[PIN_STOP]),
        .stop_fall_i (fall[PIN_STOP]),
        .hrst_fall_i (fall[PIN_HRST]),
        .core_stop_o (core_stop_o),
        .core_rst_o  (core_rst_o)
    );

    assign irq_req_o = |pending_o;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] pending_o,
    input logic              core_stop_o,
    input logic              core_rst_o,
    input logic              mck_ack_i,
    input logic [NPIN-1:0]   sync_lvl,
    input logic [NPIN-1:0]   prev_lvl
);
    // R10: a reset pulse is never longer than one cycle
    assert_rst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    // R6: the machine-check bit holds until acknowledged
    assert_mck_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o[PB_MCK] && !mck_ack_i) |=> pending_o[PB_MCK]);

    // R5: the machine-check bit only rises on a falling synchronized level
    assert_mck_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o[PB_MCK]) |-> ($past(prev_lvl[PIN_MCK]) && !$past(sync_lvl[PIN_MCK])));

    // R3: the external bit tracks the synchronized pin one cycle later
    assert_ext_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o[PB_EXT] == $past(sync_lvl[PIN_EXT]));

    // R9: halted only while the stored checkstop level is low
    assert_stop_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_stop_o |-> !prev_lvl[PIN_STOP]);
endmodule

bind irq_pin_conditioner irqc_checker u_irqc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending_o   (pending_o),
    .core_stop_o (core_stop_o),
    .core_rst_o  (core_rst_o),
    .mck_ack_i   (mck_ack_i),
    .sync_lvl    (sync_lvl),
    .prev_lvl    (prev_lvl)
);

// File: tb/test_irq_pin_conditioner.sv
module test_irq_pin_conditioner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_irq_i = 1'b0, smi_i = 1'b0, mck_n_i = 1'b1;
    logic       chkstop_n_i = 1'b1, hreset_n_i = 1'b1, sreset_i = 1'b0;
    logic       mck_ack_i = 1'b0;
    logic [3:0] pending_o;
    logic       irq_req_o, core_stop_o, core_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    int pulse_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    bit exp_mck = 1'b0;
    int exp_pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_pin_conditioner i_irq_pin_conditioner (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .smi_i(smi_i),
        .mck_n_i(mck_n_i), .chkstop_n_i(chkstop_n_i), .hreset_n_i(hreset_n_i),
        .sreset_i(sreset_i), .mck_ack_i(mck_ack_i), .pending_o(pending_o),
        .irq_req_o(irq_req_o), .core_stop_o(core_stop_o), .core_rst_o(core_rst_o)
    );

    always @(negedge clk) begin
        if (core_rst_o) begin
            run_len = run_len + 1;
            if (run_len == 1) pulse_cnt = pulse_cnt + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pend();
        return {sreset_i, exp_mck, smi_i, ext_irq_i};
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [3:0] e;
        e = exp_pend();
        check({tag, " R3/R4/R5/R7 pending"}, int'(pending_o), int'(e));
        check({tag, " R8 irq_req"}, int'(irq_req_o), int'(|e));
        check({tag, " R9 core_stop"}, int'(core_stop_o), int'(!chkstop_n_i));
        check({tag, " R10 pulse count"}, pulse_cnt, exp_pulses);
    endtask

    task automatic set_pins(input logic [5:0] v);
        if (mck_n_i && !v[2]) exp_mck = 1'b1;
        if (hreset_n_i && !v[4]) exp_pulses++;
        ext_irq_i = v[0]; smi_i = v[1]; mck_n_i = v[2];
        chkstop_n_i = v[3]; hreset_n_i = v[4]; sreset_i = v[5];
    endtask

    function automatic logic [5:0] cur_pins();
        return {sreset_i, hreset_n_i, chkstop_n_i, mck_n_i, smi_i, ext_irq_i};
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pending", int'(pending_o), 0);
        check("R1 irq_req", int'(irq_req_o), 0);
        check("R1 stop", int'(core_stop_o), 0);
        check("R1 rst", int'(core_rst_o), 0);
        rst_n = 1'b1;
        settle();
        check_all("R1 rest levels");

        // R2 latency: 3 edges
        @(negedge clk);
        ext_irq_i = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 not yet", int'(pending_o[0]), 0);
        @(negedge clk);
        check("R2 arrived", int'(pending_o[0]), 1);
        ext_irq_i = 1'b0;
        settle();
        check_all("R3 clear");

        // R5 rising edge of machine check does nothing; falling sets
        set_pins(6'b01_1000); settle(); check_all("R5 fall");
        set_pins(6'b01_1100); settle(); check_all("R5 rise ignored");
        mck_ack_i = 1'b1; @(negedge clk); mck_ack_i = 1'b0; exp_mck = 1'b0;
        settle(); check_all("R6 ack clears");
        mck_ack_i = 1'b1; @(negedge clk); mck_ack_i = 1'b0;
        settle(); check_all("R6 ack while clear");

        // R10 hold low: one pulse only
        set_pins(6'b00_1100); repeat (20) @(negedge clk); check_all("R10 held low");
        set_pins(6'b01_1100); settle(); check_all("R10 release");

        // R11 re-drive current level: no event
        set_pins(cur_pins()); settle(); check_all("R11 no change");

        // random walk
        for (int i = 0; i < 150; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                mck_ack_i = 1'b1; @(negedge clk); mck_ack_i = 1'b0; exp_mck = 1'b0;
            end
            set_pins(cur_pins() ^ 6'($urandom_range(0, 63)));
            settle();
            check_all("rand");
        end
        check("R10 pulse width", max_run, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule